// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block produces the oversampling tick for one serial channel: a single-cycle pulse whose rate is the reference clock divided by a programmable 16-bit divisor. A channel that samples at sixteen times its bit rate uses divisor = f_ref / (16 × baud). For example, with a 1.8432 MHz reference the divisor is 2304 (0x0900) for 50 baud, 384 (0x0180) for 300 baud, 12 (0x000C) for 9600 baud and 1 (0x0001) for 115200 baud. All of these divide exactly.

Software reaches the block through a small byte-wide register bus. The divisor is held in two byte latches. They can only be reached while the mode byte opens them. Writing either latch restarts the count at once from the new full divisor. The divisor latches have no reset, so a master reset does not change them. The mode byte and a free scratch byte do have reset values.

The generator is a two-state machine. In GEN_HALT it holds the tick low and does not count. GEN_HALT is entered on reset and on a latch write that leaves the divisor at zero. GEN_HALT goes to GEN_RUN in two cases: a latch write that leaves the divisor nonzero, or a nonzero divisor found after reset. In GEN_RUN the counter counts down. It emits the tick at count 1 and reloads. GEN_RUN goes back to GEN_HALT only on a latch write of a zero divisor. Any other latch write stays in GEN_RUN and reloads the counter.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset, the mode byte reads 0x00 and the scratch byte reads 0xFF. `rdata` is 0 whenever `rd_en` is low.
- R2: The mode byte is at offset 3 and can be read and written.
- R3: The low divisor byte is at offset 0 and the high byte is at offset 1. Both can be read and written while mode bit 7 is 1 and the mode byte is not 0xBF.
- R4: While mode bit 7 is 0, or the mode byte equals 0xBF, writes to offsets 0 and 1 leave the latches unchanged, and reads of those offsets return 0.
- R5: A latch write loads the counter with the full new divisor N at the write edge E0. The first tick is high between edges E(N-1) and E(N).
- R6: With a divisor N ≥ 2, the tick is one cycle wide and repeats exactly every N cycles.
- R7: With a divisor of 1, the tick is high on every cycle.
- R8: With a divisor of 0, the tick stays low. A later nonzero write restarts the count as R5 describes.
- R9: Reset leaves the divisor latches unchanged. After reset, ticking resumes with the retained period.
- R10: The scratch byte at offset 7 stores any value and has no effect on the tick.
- R11: A latch write in the same cycle as a tick takes priority over the reload. The next tick follows the new divisor as R5 describes.
- R12: Reads of offsets 2, 4, 5 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low master reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational, 0 when not reading) |
| tick | output | 1 | Oversampling tick, one cycle wide |

## Verification
A latch write and a terminal count can fall on the same clock edge. In that case the counter could either reload the old divisor or load the new one. The bench provokes this by waiting until the tick is high, then presenting a latch write in that cycle. It judges the result by checking that the following ticks fall at the new divisor's offsets from the write edge. A scratch write during active counting is likewise checked against the undisturbed tick pattern.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int NUM_LATCH = 2;
    localparam int DIV_W     = DATA_W * NUM_LATCH;

    localparam logic [ADDR_W-1:0] OFS_MODE    = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH = 3'd7;

    localparam logic [DATA_W-1:0] MODE_RESET    = 8'h00;
    localparam logic [DATA_W-1:0] SCRATCH_RESET = 8'hFF;
    localparam logic [DATA_W-1:0] MODE_LOCKED   = 8'hBF;
    localparam int                MODE_OPEN_BIT = 7;

    typedef enum logic [0:0] {
        GEN_HALT = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_t;
endpackage

// File: rtl/uart_rate_regs.sv
module uart_rate_regs
    import uart_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DIV_W-1:0]  divisor,
    output logic [DIV_W-1:0]  div_next,
    output logic              div_load,
    output logic [DATA_W-1:0] mode_q
);
    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] lat_q [NUM_LATCH];
    logic              latch_open;
    logic [NUM_LATCH-1:0] lat_hit;

    assign latch_open = mode_q[MODE_OPEN_BIT] && (mode_q != MODE_LOCKED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_RESET;
            scratch_q <= SCRATCH_RESET;
        end else if (wr_en) begin
            if (addr == OFS_MODE)    mode_q    <= wdata;
            if (addr == OFS_SCRATCH) scratch_q <= wdata;
        end
    end

    for (genvar b = 0; b < NUM_LATCH; b++) begin : g_latch
        assign lat_hit[b] = wr_en && latch_open && (addr == ADDR_W'(b));

        always_ff @(posedge clk) begin
            if (lat_hit[b]) lat_q[b] <= wdata;
        end

        assign divisor[b*DATA_W +: DATA_W]  = lat_q[b];
        assign div_next[b*DATA_W +: DATA_W] = lat_hit[b] ? wdata : lat_q[b];
    end

    assign div_load = |lat_hit;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == OFS_MODE)    rdata = mode_q;
            if (addr == OFS_SCRATCH) rdata = scratch_q;
            for (int b = 0; b < NUM_LATCH; b++) begin
                if (latch_open && addr == ADDR_W'(b)) rdata = lat_q[b];
            end
        end
    end
endmodule

// File: rtl/uart_rate_cnt.sv
module uart_rate_cnt
    import uart_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    gen_state_t       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d   = load_val;
            state_d = (load_val == '0) ? GEN_HALT : GEN_RUN;
        end else begin
            unique case (state_q)
                GEN_HALT: begin
                    if (divisor != '0) begin
                        cnt_d   = divisor;
                        state_d = GEN_RUN;
                    end
                end
                GEN_RUN: begin
                    if (cnt_q == ONE) cnt_d = divisor;
                    else              cnt_d = cnt_q - ONE;
                end
                default: state_d = GEN_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            GEN_HALT: tick = 1'b0;
            GEN_RUN:  tick = (cnt_q == ONE);
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
    import uart_rate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        tick
);
    logic [DIV_W-1:0]  divisor;
    logic [DIV_W-1:0]  div_next;
    logic              div_load;
    logic [DATA_W-1:0] mode_q;

    uart_rate_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .divisor  (divisor),
        .div_next (div_next),
        .div_load (div_load),
        .mode_q   (mode_q)
    );

    uart_rate_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .load_val (div_next),
        .divisor  (divisor),
        .tick     (tick)
    );
endmodule

// File: rtl/uart_rate_gen_chk.sv
module uart_rate_gen_chk
    import uart_rate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] mode_q,
    input logic [DIV_W-1:0]  divisor,
    input logic [DIV_W-1:0]  div_next,
    input logic              div_load,
    input logic              tick
);
    // R1
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    // R4
    closed_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[MODE_OPEN_BIT] || mode_q == MODE_LOCKED) |=> $stable(divisor));

    // R5
    first_tick_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_load && div_next > DIV_W'(1)) |=> !tick);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > DIV_W'(1) && !div_load) |=> !tick);

    // R7
    unit_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> (divisor != DIV_W'(1) || tick));

    // R8
    zero_divisor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        divisor == '0 |-> !tick);
endmodule

bind uart_rate_gen uart_rate_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .mode_q   (mode_q),
    .divisor  (divisor),
    .div_next (div_next),
    .div_load (div_load),
    .tick     (tick)
);

// File: tb/uart_rate_gen_test.sv
module uart_rate_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    uart_rate_gen uut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata),
        .tick  (tick)
    );

    typedef struct packed {
        logic       is_rd;
        logic [2:0] a;
        logic [7:0] d;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd3, 8'h80, 8'd2},   // R2 open latches
        '{1'b1, 3'd3, 8'h80, 8'd2},   // R2
        '{1'b0, 3'd0, 8'h34, 8'd3},   // R3
        '{1'b0, 3'd1, 8'h12, 8'd3},   // R3
        '{1'b1, 3'd0, 8'h34, 8'd3},   // R3
        '{1'b1, 3'd1, 8'h12, 8'd3},   // R3
        '{1'b0, 3'd7, 8'h5A, 8'd10},  // R10
        '{1'b1, 3'd7, 8'h5A, 8'd10},  // R10
        '{1'b1, 3'd2, 8'h00, 8'd12},  // R12
        '{1'b1, 3'd4, 8'h00, 8'd12},  // R12
        '{1'b1, 3'd6, 8'h00, 8'd12},  // R12
        '{1'b0, 3'd3, 8'h03, 8'd4},   // R4 close latches
        '{1'b1, 3'd0, 8'h00, 8'd4},   // R4
        '{1'b1, 3'd1, 8'h00, 8'd4},   // R4
        '{1'b0, 3'd0, 8'h77, 8'd4},   // R4 ignored write
        '{1'b0, 3'd3, 8'hBF, 8'd4},   // R4 locked value
        '{1'b1, 3'd3, 8'hBF, 8'd2},   // R2
        '{1'b1, 3'd0, 8'h00, 8'd4},   // R4
        '{1'b0, 3'd1, 8'h99, 8'd4},   // R4 ignored write
        '{1'b0, 3'd3, 8'h83, 8'd4},   // R4 reopen
        '{1'b1, 3'd0, 8'h34, 8'd4},   // R4 latches unchanged
        '{1'b1, 3'd1, 8'h12, 8'd4}    // R4
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a; rd_en = 1'b1;
        #1;
        check(rdata == exp, tag, rdata, exp);
        rd_en = 1'b0;
        #1;
    endtask

    // Sample intervals k0..k1 after a write edge; expect tick when (k+1)%n==0.
    task automatic ticks(input int n, input int k0, input int k1, input string tag);
        for (int k = k0; k <= k1; k++) begin
            bit exp;
            exp = (n != 0) && (((k + 1) % n) == 0);
            check(tick == exp, tag, tick, exp);
            @(negedge clk);
        end
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 100; i++) begin
            if (tick) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values and idle bus
        check(rdata == 8'h00, "R1 idle rdata", rdata, 0);
        rd(3'd3, 8'h00, "R1 mode reset");
        rd(3'd7, 8'hFF, "R1 scratch reset");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) rd(VECS[i].a, VECS[i].d, $sformatf("R%0d vec %0d", VECS[i].req, i));
            else               wr(VECS[i].a, VECS[i].d);
        end

        // R5 / R6: divisor 5
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h00);
        ticks(5, 0, 14, "R6 div5");
        // R7: divisor 1
        wr(3'd0, 8'h01);
        ticks(1, 0, 7, "R7 div1");
        // R8: divisor 0
        wr(3'd0, 8'h00);
        ticks(0, 0, 19, "R8 div0");
        // R8 resume, R5 first tick
        wr(3'd0, 8'h03);
        ticks(3, 0, 8, "R5 resume div3");
        // R10 scratch write while counting
        wr(3'd0, 8'h03);
        wr(3'd7, 8'hC3);
        ticks(3, 1, 8, "R10 scratch no effect");
        // R11 write lands on a tick cycle
        wr(3'd0, 8'h04);
        wait_tick();
        check(tick == 1'b1, "R11 tick seen", tick, 1);
        wr(3'd0, 8'h06);
        ticks(6, 0, 11, "R11 collision");
        // R9 latches survive reset
        wr(3'd0, 8'h03);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd7, 8'hFF, "R9 scratch back to reset");
        wait_tick();
        check(tick == 1'b1, "R9 tick resumes", tick, 1);
        @(negedge clk);
        ticks(3, 0, 5, "R9 period kept");
        wr(3'd3, 8'h80);
        rd(3'd0, 8'h03, "R9 low latch kept");
        rd(3'd1, 8'h00, "R9 high latch kept");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule